// File: doc/BRIEF.md
# SPI-4.2 Transmit Packet Framer

This block turns a stream of 16-bit packet words, each marked with start, end, port and end-byte information, into the transmit word stream of a SPI-4.2 link. It emits exactly one 16-bit word per clock on `tx_word`, and `tx_ctl` flags whether that word is a control word or a payload word. It opens every burst with a control word that names the port and whether a new packet begins. It reports each packet end with its end status. It fills every slot that carries no payload with the idle control word 16'h000F. Every control word carries a four-bit parity over the payload it closes.

A build parameter picks between two modes. In lite mode every burst starts on a boundary of the full bus width, which is 4 words (8 bytes) for a 64-bit bus or 8 words for a 128-bit bus, and a packet end is always reported in its own control word. In packed mode bursts start on 2-word (4-byte) boundaries. When the next packet's first word is already waiting at an aligned slot, the end of one packet and the start of the next are reported in a single control word. The upstream source offers one word at a time and it is taken in every cycle in which `in_ready` is high.

Top module: `spi4tx_framer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `tx_word` is 16'h000F with `tx_ctl` high.
- R2: When no payload and no packet end is pending, the output is the idle control word 16'h000F with `tx_ctl` high.
- R3: Control word fields: bit 15 is set when payload follows; bits 14:13 hold the end status of the packet just finished; bit 12 marks a packet start; bits 11:4 hold the port for words with bit 15 set and are zero otherwise; bits 3:0 hold the parity.
- R4: End status codes: 00 no end, 01 aborted packet, 10 last word holds one valid byte (`in_odd`=1), 11 last word holds two valid bytes.
- R5: The parity takes the XOR of all payload words sent since the previous control word and of the current control word with bits 3:0 set to 1111. It then XORs the four nibbles of that 16-bit result together.
- R6: Payload words come out unchanged, in order and with `tx_ctl` low. A payload word appears only in the cycle after the source word was taken.
- R7: A control word with bit 15 set appears only at output word positions that are multiples of the alignment. Positions count from 0 at the first word after reset. The alignment is BUS_BITS/16 words in lite mode and 2 words in packed mode.
- R8: In packed mode, a packet end is merged into the next packet's start control word (bits 15 and 12 set, end status in 14:13) when that packet's first word is valid at the aligned slot that directly follows the last payload word. In every other case the end goes out in its own control word with bit 15 clear.
- R9: In lite mode the end status is never merged: a control word with bit 12 set always carries end status 00.
- R10: If the source has no valid word during a burst, the burst closes with a control word that has bit 15 clear and end status 00. When the packet resumes, it does so with a continuation control word whose bits 15:12 are 4'b1000.
- R11: `in_ready` is high exactly in the cycles that follow a control word with bit 15 set or a payload word that is not a packet's last and is not followed by a gap. The first payload word directly follows its control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source word valid |
| in_data | input | 16 | Source payload word |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_odd | input | 1 | Last word carries one valid byte |
| in_abort | input | 1 | Packet ending with this word is aborted |
| in_port | input | 8 | Port the packet belongs to |
| in_ready | output | 1 | Source word is taken this cycle when valid |
| tx_word | output | 16 | Transmit word |
| tx_ctl | output | 1 | High when `tx_word` is a control word |

## Verification
The assertions check these rules on every cycle: burst starts fall only on aligned word positions, a payload word appears only after a taken source word and equals that word, a gap during a burst closes it, words with bit 15 clear carry no port, lite mode never merges, and `in_ready` follows a burst-opening control word. The exact contents of each control word are shown only by the bench scenarios. These are the parity value, which end codes go out for aborted, odd and even ends, and whether an end merges with the next start in packed mode or goes out alone. The scenarios compare those words against expected lists built from the requirements.

// File: rtl/spi4tx_pkg.sv
`timescale 1ns/1ps
package spi4tx_pkg;
    localparam int WORD_W = 16;
    localparam int PORT_W = 8;
    localparam logic [WORD_W-1:0] IDLE_WORD = 16'h000F;

    typedef enum logic [1:0] {
        END_NONE  = 2'b00,
        END_ABORT = 2'b01,
        END_ONE   = 2'b10,
        END_TWO   = 2'b11
    } end_code_e;

    // upper twelve bits of a control word
    typedef struct packed {
        logic              more;
        end_code_e         fin;
        logic              first;
        logic [PORT_W-1:0] port;
    } ctl_head_t;

    function automatic logic [3:0] nib_fold(input logic [WORD_W-1:0] w);
        return w[15:12] ^ w[11:8] ^ w[7:4] ^ w[3:0];
    endfunction

    function automatic logic [WORD_W-1:0] seal_ctl(input ctl_head_t h,
                                                   input logic [WORD_W-1:0] acc);
        logic [WORD_W-1:0] base;
        base = {h, 4'hF};
        return {h, nib_fold(acc ^ base)};
    endfunction

    function automatic end_code_e pick_end(input logic abort, input logic odd);
        if (abort)
            return END_ABORT;
        else if (odd)
            return END_ONE;
        else
            return END_TWO;
    endfunction
endpackage

// File: rtl/spi4tx_phase.sv
`timescale 1ns/1ps
module spi4tx_phase #(
    parameter int ALIGN_W = 2
) (
    input  logic clk,
    input  logic rst,
    output logic aligned
);
    localparam int CW = (ALIGN_W > 1) ? $clog2(ALIGN_W) : 1;

    generate
        if (ALIGN_W <= 1) begin : g_free
            assign aligned = 1'b1;
        end else begin : g_count
            logic [CW-1:0] pos_q;
            always_ff @(posedge clk) begin
                if (rst)
                    pos_q <= '0;
                else if (pos_q == CW'(ALIGN_W - 1))
                    pos_q <= '0;
                else
                    pos_q <= pos_q + 1'b1;
            end
            assign aligned = (pos_q == '0);
        end
    endgenerate
endmodule

// File: rtl/spi4tx_parity_acc.sv
`timescale 1ns/1ps
module spi4tx_parity_acc
    import spi4tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              clear,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (take)
            acc <= acc ^ data;
    end
endmodule

// File: rtl/spi4tx_seq.sv
`timescale 1ns/1ps
module spi4tx_seq
    import spi4tx_pkg::*;
#(
    parameter bit MERGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_odd,
    input  logic              in_abort,
    input  logic [PORT_W-1:0] in_port,
    input  logic              aligned,
    output logic              in_ready,
    output logic              take,
    output logic              emit_ctl,
    output ctl_head_t         head
);
    logic      burst_q;
    logic      pend_q;
    end_code_e pend_code_q;
    logic      start;

    assign in_ready = burst_q;

    always_comb begin
        take       = 1'b0;
        emit_ctl   = 1'b1;
        start      = 1'b0;
        head.more  = 1'b0;
        head.fin   = END_NONE;
        head.first = 1'b0;
        head.port  = '0;
        if (burst_q) begin
            if (in_valid) begin
                take     = 1'b1;
                emit_ctl = 1'b0;
            end
        end else if (pend_q) begin
            head.fin = pend_code_q;
            if (MERGE && in_valid && in_sop && aligned) begin
                head.more  = 1'b1;
                head.first = 1'b1;
                head.port  = in_port;
                start      = 1'b1;
            end
        end else if (in_valid && aligned) begin
            head.more  = 1'b1;
            head.first = in_sop;
            head.port  = in_port;
            start      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q     <= 1'b0;
            pend_q      <= 1'b0;
            pend_code_q <= END_NONE;
        end else begin
            burst_q <= burst_q ? (in_valid && !in_eop) : start;
            if (take && in_eop) begin
                pend_q      <= 1'b1;
                pend_code_q <= pick_end(in_abort, in_odd);
            end else if (!burst_q) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi4tx_framer.sv
`timescale 1ns/1ps
module spi4tx_framer
    import spi4tx_pkg::*;
#(
    parameter bit LITE     = 1'b0,
    parameter int BUS_BITS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_odd,
    input  logic              in_abort,
    input  logic [PORT_W-1:0] in_port,
    output logic              in_ready,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_ctl
);
    localparam int ALIGN_W = LITE ? (BUS_BITS / WORD_W) : 2;

    logic              aligned;
    logic              take;
    logic              emit_ctl;
    ctl_head_t         head;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] nxt_word;

    spi4tx_phase #(.ALIGN_W(ALIGN_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .aligned (aligned)
    );

    spi4tx_seq #(.MERGE(!LITE)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_odd   (in_odd),
        .in_abort (in_abort),
        .in_port  (in_port),
        .aligned  (aligned),
        .in_ready (in_ready),
        .take     (take),
        .emit_ctl (emit_ctl),
        .head     (head)
    );

    spi4tx_parity_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .clear (emit_ctl),
        .data  (in_data),
        .acc   (acc)
    );

    always_comb begin
        nxt_word = emit_ctl ? seal_ctl(head, acc) : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word <= IDLE_WORD;
            tx_ctl  <= 1'b1;
        end else begin
            tx_word <= nxt_word;
            tx_ctl  <= emit_ctl;
        end
    end
endmodule

// File: rtl/spi4tx_framer_chk.sv
`timescale 1ns/1ps
module spi4tx_framer_chk #(
    parameter bit LITE     = 1'b0,
    parameter int BUS_BITS = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] in_data,
    input logic        in_ready,
    input logic [15:0] tx_word,
    input logic        tx_ctl
);
    localparam int AW = LITE ? (BUS_BITS / 16) : 2;
    localparam int IW = (AW > 1) ? $clog2(AW) : 1;

    logic [IW-1:0] idx_q;
    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (idx_q == IW'(AW - 1))
            idx_q <= '0;
        else
            idx_q <= idx_q + 1'b1;
    end

    // R7: burst-opening control words only on aligned positions
    a_r7_burst_aligned: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl && tx_word[15]) |-> ($past(idx_q) == '0));

    // R6: payload word equals the word taken one cycle earlier
    a_r6_payload_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> (!tx_ctl && tx_word == $past(in_data)));

    // R6: no payload word without a taken source word
    a_r6_no_stray_payload: assert property (@(posedge clk) disable iff (rst)
        !tx_ctl |-> $past(in_ready && in_valid));

    // R10: a gap inside a burst closes it
    a_r10_gap_closes: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (tx_ctl && tx_word[15:13] == 3'b000));

    // R3: words without following payload carry no port and no start
    a_r3_idle_no_port: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl && !tx_word[15]) |-> (tx_word[12:4] == 9'd0));

    // R11: a burst-opening control word is followed by readiness
    a_r11_ready_after_open: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl && tx_word[15]) |-> in_ready);

    generate
        if (LITE) begin : g_lite
            // R9: lite mode never merges an end into a start
            a_r9_no_merge: assert property (@(posedge clk) disable iff (rst)
                (tx_ctl && tx_word[15] && tx_word[12]) |-> (tx_word[14:13] == 2'b00));
        end
    endgenerate
endmodule

bind spi4tx_framer spi4tx_framer_chk #(.LITE(LITE), .BUS_BITS(BUS_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .tx_word  (tx_word),
    .tx_ctl   (tx_ctl)
);

// File: tb/tb_spi4tx_framer.sv
`timescale 1ns/1ps
module tb_spi4tx_framer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        v_valid [2];
    logic [15:0] v_data  [2];
    logic        v_sop   [2];
    logic        v_eop   [2];
    logic        v_odd   [2];
    logic        v_abort [2];
    logic [7:0]  v_port  [2];
    logic        v_ready [2];
    logic [15:0] v_tx    [2];
    logic        v_ctl   [2];

    spi4tx_framer #(.LITE(1'b0), .BUS_BITS(64)) dut (
        .clk(clk), .rst(rst), .in_valid(v_valid[0]), .in_data(v_data[0]),
        .in_sop(v_sop[0]), .in_eop(v_eop[0]), .in_odd(v_odd[0]),
        .in_abort(v_abort[0]), .in_port(v_port[0]), .in_ready(v_ready[0]),
        .tx_word(v_tx[0]), .tx_ctl(v_ctl[0]));

    spi4tx_framer #(.LITE(1'b1), .BUS_BITS(64)) dut_lite (
        .clk(clk), .rst(rst), .in_valid(v_valid[1]), .in_data(v_data[1]),
        .in_sop(v_sop[1]), .in_eop(v_eop[1]), .in_odd(v_odd[1]),
        .in_abort(v_abort[1]), .in_port(v_port[1]), .in_ready(v_ready[1]),
        .tx_word(v_tx[1]), .tx_ctl(v_ctl[1]));

    int tests = 0;
    int fails = 0;
    bit run = 1'b0;
    int idx = 0;
    logic [16:0] q0[$], q1[$];
    string       t0[$], t1[$];
    logic [16:0] prev [2];

    // R5: parity over accumulated payload and control word with 1111 in bits 3:0
    function automatic logic [15:0] cw(input logic t, input logic [1:0] e, input logic s,
                                       input logic [7:0] p, input logic [15:0] acc);
        logic [15:0] b, f;
        b = {t, e, s, p, 4'hF};
        f = acc ^ b;
        return {b[15:4], f[15:12] ^ f[11:8] ^ f[7:4] ^ f[3:0]};
    endfunction

    task automatic expw(input int m, input logic c, input logic [15:0] w, input string tg);
        if (m == 0) begin q0.push_back({c, w}); t0.push_back(tg); end
        else        begin q1.push_back({c, w}); t1.push_back(tg); end
    endtask

    task automatic put(input int m, input logic [15:0] d, input logic sop, input logic eop,
                       input logic odd, input logic abt, input logic [7:0] port);
        logic rdy;
        v_valid[m] = 1'b1; v_data[m] = d; v_sop[m] = sop; v_eop[m] = eop;
        v_odd[m] = odd; v_abort[m] = abt; v_port[m] = port;
        forever begin
            rdy = v_ready[m];
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        v_valid[m] = 1'b0;
    endtask

    task automatic mon(input int m);
        logic [16:0] got, ex;
        string tg;
        int al;
        got = {v_ctl[m], v_tx[m]};
        al = (m == 0) ? 2 : 4;
        if (got != {1'b1, 16'h000F}) begin
            if (got[16] && got[15]) begin
                tests++;
                if (idx % al != 0) begin
                    fails++;
                    $display("FAIL R7 dut%0d burst start at position %0d (actual), expected multiple of %0d", m, idx, al);
                end
            end
            if (!got[16]) begin
                tests++;
                if (!(prev[m][16] == 1'b0 || prev[m][15])) begin
                    fails++;
                    $display("FAIL R11 dut%0d payload after %h (actual), expected after opening control or payload", m, prev[m]);
                end
            end
            if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
                tests++; fails++;
                $display("FAIL R2 dut%0d unexpected word %h (actual), expected idle 1000f", m, got);
            end else begin
                if (m == 0) begin ex = q0.pop_front(); tg = t0.pop_front(); end
                else        begin ex = q1.pop_front(); tg = t1.pop_front(); end
                tests++;
                if (got != ex) begin
                    fails++;
                    $display("FAIL %s dut%0d word %h (actual), expected %h", tg, m, got, ex);
                end
            end
        end
        prev[m] = got;
    endtask

    always @(negedge clk) begin
        if (run) begin
            mon(0);
            mon(1);
            idx++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (actual), expected run to finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            v_valid[m] = 0; v_data[m] = '0; v_sop[m] = 0; v_eop[m] = 0;
            v_odd[m] = 0; v_abort[m] = 0; v_port[m] = '0;
            prev[m] = {1'b1, 16'h000F};
        end
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            tests++;
            if ({v_ctl[m], v_tx[m]} != {1'b1, 16'h000F}) begin
                fails++;
                $display("FAIL R1 dut%0d reset word %h (actual), expected 1000f", m, {v_ctl[m], v_tx[m]});
            end
        end
        rst = 1'b0;
        @(posedge clk);
        run = 1'b1;
        repeat (6) begin
            @(negedge clk);
            for (int m = 0; m < 2; m++) begin
                tests++;
                if ({v_ctl[m], v_tx[m]} != {1'b1, 16'h000F}) begin
                    fails++;
                    $display("FAIL R2 dut%0d idle word %h (actual), expected 1000f", m, {v_ctl[m], v_tx[m]});
                end
            end
        end

        // packed: odd-length packet merges its end into the next start (R8), even-length does not
        expw(0, 1, cw(1, 2'b00, 1, 8'h05, 16'h0), "R3");
        expw(0, 0, 16'h1234, "R6");
        expw(0, 0, 16'h5678, "R6");
        expw(0, 0, 16'h9A00, "R6");
        expw(0, 1, cw(1, 2'b10, 1, 8'h21, 16'h1234 ^ 16'h5678 ^ 16'h9A00), "R8");
        expw(0, 0, 16'hAAAA, "R6");
        expw(0, 0, 16'h0F0F, "R6");
        expw(0, 1, cw(0, 2'b11, 0, 8'h00, 16'hAAAA ^ 16'h0F0F), "R8");
        put(0, 16'h1234, 1, 0, 0, 0, 8'h05);
        put(0, 16'h5678, 0, 0, 0, 0, 8'h05);
        put(0, 16'h9A00, 0, 1, 1, 0, 8'h05);
        put(0, 16'hAAAA, 1, 0, 0, 0, 8'h21);
        put(0, 16'h0F0F, 0, 1, 0, 0, 8'h21);
        repeat (6) @(negedge clk);

        // packed: gap closes burst, continuation resumes, aborted end (R10, R4)
        expw(0, 1, cw(1, 2'b00, 1, 8'h7F, 16'h0), "R3");
        expw(0, 0, 16'h1234, "R6");
        expw(0, 1, cw(0, 2'b00, 0, 8'h00, 16'h1234), "R10");
        expw(0, 1, cw(1, 2'b00, 0, 8'h7F, 16'h0), "R10");
        expw(0, 0, 16'h4321, "R6");
        expw(0, 1, cw(0, 2'b01, 0, 8'h00, 16'h4321), "R4");
        put(0, 16'h1234, 1, 0, 0, 0, 8'h7F);
        repeat (3) @(negedge clk);
        put(0, 16'h4321, 0, 1, 0, 1, 8'h7F);
        repeat (6) @(negedge clk);

        // packed: single-word packet, two valid bytes, parity over one word (R5)
        expw(0, 1, cw(1, 2'b00, 1, 8'h10, 16'h0), "R11");
        expw(0, 0, 16'hBEEF, "R6");
        expw(0, 1, cw(0, 2'b11, 0, 8'h00, 16'hBEEF), "R5");
        put(0, 16'hBEEF, 1, 1, 0, 0, 8'h10);
        repeat (6) @(negedge clk);

        // lite: same traffic, end always separate, starts on 4-word boundaries (R9, R7)
        expw(1, 1, cw(1, 2'b00, 1, 8'h05, 16'h0), "R7");
        expw(1, 0, 16'h1234, "R6");
        expw(1, 0, 16'h5678, "R6");
        expw(1, 0, 16'h9A00, "R6");
        expw(1, 1, cw(0, 2'b10, 0, 8'h00, 16'h1234 ^ 16'h5678 ^ 16'h9A00), "R9");
        expw(1, 1, cw(1, 2'b00, 1, 8'h21, 16'h0), "R9");
        expw(1, 0, 16'hAAAA, "R6");
        expw(1, 0, 16'h0F0F, "R6");
        expw(1, 1, cw(0, 2'b11, 0, 8'h00, 16'hAAAA ^ 16'h0F0F), "R4");
        put(1, 16'h1234, 1, 0, 0, 0, 8'h05);
        put(1, 16'h5678, 0, 0, 0, 0, 8'h05);
        put(1, 16'h9A00, 0, 1, 1, 0, 8'h05);
        put(1, 16'hAAAA, 1, 0, 0, 0, 8'h21);
        put(1, 16'h0F0F, 0, 1, 0, 0, 8'h21);
        repeat (12) @(negedge clk);

        tests++;
        if (q0.size() != 0 || q1.size() != 0) begin
            fails++;
            $display("FAIL R6 words still expected %0d/%0d (actual), expected 0/0", q0.size(), q1.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule